// File: doc/BRIEF.md
# Priority Counter Request Arbiter

This block queues count requests for a small set of up/down counters that live in memory. It does not hold the counts itself. Each counter has a plus cell and a minus cell. A rising edge on the counter's up or down input sets the matching cell. A shared 100 Hz tick sets the plus cells of the three timers. A priority encoder keeps track of which pending counter has the lowest address.

The sequencer drives a set of active-low command pulses:
- A latch command captures the winning counter and a two-bit subsequence code. The code tells the sequencer whether to run an increment step, a decrement step or no step.
- A read command places the captured counter's memory address on the read bus for one cycle and pulls BUSY low.
- A clear command releases the captured counter's cells. It also checks the write-bus sign (SG) and overflow (US) bits for a positive overflow.

A positive overflow of the low clock word requests an increment of the high clock word. Overflow of either of the two other timers raises a one-cycle interrupt request. A separate overflow-check command turns an arithmetic overflow on the write bus into a plus or minus request on the overflow counter.

Top module: `ctr_req_arbiter`

## Requirements
- R1: After a synchronous active-high `rst`, or a cycle with `genrst_n` low, `sub_sel` is 00 and both interrupt outputs are 0. After either, all cells are empty, so a later latch gives 00 and counter index 0. After `rst`, `rbus` is 0 and `rbus_busy_n` is 1.
- R2: A cell is set only by a 0-to-1 change of its count input. An input held high does not set the cell again once it has been cleared.
- R3: Counters use indices 0..4. Index 0 is the overflow counter, 1 the high clock word, 2 the low clock word, 3 the general timer and 4 the display timer. When several counters are pending, the lowest index wins.
- R4: A cycle with `wpctr_n` low latches the winner and sets `sub_sel` on the next edge. The code is 01 for plus only and 10 for minus only. The code is 00 when nothing is pending, and the latched index is then 0.
- R5: A counter with both cells set still wins arbitration but gives `sub_sel` 00. The clear command empties both of its cells.
- R6: A cycle with `rsct_n` low makes `rbus` equal 28 (octal 034) plus the latched index on the next cycle, with `rbus_busy_n` 0. In every other cycle `rbus` is 0 and `rbus_busy_n` is 1.
- R7: `wovr_n` low clears only the latched counter's cells, and only once per latch. Other pending requests remain.
- R8: A positive overflow is write-bus US=1 with SG=0. If it is present during a clear of index 3, `rupt_t3` is high for exactly the next cycle. The same holds for index 4 and `rupt_t4`. No pulse follows a clear with no overflow or with a negative overflow.
- R9: A clear of index 2 with a positive overflow sets the plus cell of index 1.
- R10: A rising edge of `tick` sets the plus cells of indices 2, 3 and 4.
- R11: With `wovc_n` low, US=1/SG=0 sets the plus cell of index 0 and SG=1/US=0 sets its minus cell. Other bus values set nothing.
- R12: `sub_sel` holds its value between latch commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up | input | NCNT | Per-counter plus request, rising-edge sensitive |
| cnt_dn | input | NCNT | Per-counter minus request, rising-edge sensitive |
| tick | input | 1 | 100 Hz timer tick, rising-edge sensitive |
| wpctr_n | input | 1 | Latch winner and subsequence code (active low) |
| rsct_n | input | 1 | Drive latched counter address on read bus (active low) |
| wovr_n | input | 1 | Clear latched cells and check overflow (active low) |
| wovc_n | input | 1 | Overflow check into overflow counter (active low) |
| genrst_n | input | 1 | General reset of cells and latches (active low) |
| wb_sg | input | 1 | Write-bus sign bit |
| wb_us | input | 1 | Write-bus overflow bit |
| sub_sel | output | 2 | Subsequence code: 00 none, 01 increment, 10 decrement |
| rbus | output | AW | Read-bus data, zero when idle |
| rbus_busy_n | output | 1 | Low while this block drives the read bus |
| rupt_t3 | output | 1 | One-cycle general-timer interrupt request |
| rupt_t4 | output | 1 | One-cycle display-timer interrupt request |

## Verification
A wrong cell state is not visible at the ports directly. It shows up at the next latch as a wrong `sub_sel` code, or one read later as a wrong address on `rbus`. A stuck cell keeps the same counter winning after its clear. A lost cell lets a lower-priority address appear too early. Overflow faults show one cycle after the clear, either as a missing or extra interrupt pulse or as the high clock word appearing at the next latch. Each check therefore chains latch, read and clear, so every stored state reaches an output within three cycles.

// File: rtl/ctr_arb_pkg.sv
package ctr_arb_pkg;
  typedef enum logic [1:0] {
    SUB_NONE = 2'b00,
    SUB_INC  = 2'b01,
    SUB_DEC  = 2'b10
  } sub_e;
endpackage

// File: rtl/ctr_cells.sv
module ctr_cells #(
  parameter int NCNT = 5,
  parameter int IDX_OV = 0,
  parameter int IDX_T2 = 1,
  parameter logic [NCNT-1:0] TICK_MASK = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_all,
  input  logic [NCNT-1:0] up_in,
  input  logic [NCNT-1:0] dn_in,
  input  logic            tick,
  input  logic            ovc_pos,
  input  logic            ovc_neg,
  input  logic            chain_set,
  input  logic [NCNT-1:0] clr_vec,
  output logic [NCNT-1:0] p_cell,
  output logic [NCNT-1:0] m_cell
);
  logic [NCNT-1:0] up_q, dn_q, up_edge, dn_edge, set_p, set_m;
  logic            tick_q, tick_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q   <= '0;
      dn_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      up_q   <= up_in;
      dn_q   <= dn_in;
      tick_q <= tick;
    end
  end

  assign up_edge   = up_in & ~up_q;
  assign dn_edge   = dn_in & ~dn_q;
  assign tick_edge = tick & ~tick_q;

  for (genvar i = 0; i < NCNT; i++) begin : g_cell
    localparam bit IS_OV = (i == IDX_OV);
    localparam bit IS_T2 = (i == IDX_T2);
    assign set_p[i] = up_edge[i] | (tick_edge & TICK_MASK[i])
                    | (IS_OV & ovc_pos) | (IS_T2 & chain_set);
    assign set_m[i] = dn_edge[i] | (IS_OV & ovc_neg);

    // a fresh request in the same cycle as a clear is kept
    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        p_cell[i] <= 1'b0;
        m_cell[i] <= 1'b0;
      end else begin
        if (set_p[i])        p_cell[i] <= 1'b1;
        else if (clr_vec[i]) p_cell[i] <= 1'b0;
        if (set_m[i])        m_cell[i] <= 1'b1;
        else if (clr_vec[i]) m_cell[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctr_prio_enc.sv
module ctr_prio_enc #(
  parameter int NCNT = 5,
  parameter int CW = 3
) (
  input  logic [NCNT-1:0] req,
  output logic [CW-1:0]   idx,
  output logic            any
);
  always_comb begin
    idx = '0;
    for (int i = NCNT - 1; i >= 0; i--) begin
      if (req[i]) idx = CW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/ctr_req_arbiter.sv
module ctr_req_arbiter #(
  parameter int NCNT = 5,
  parameter int AW = 16,
  parameter int BASE_ADDR = 28,
  parameter int IDX_OV = 0,
  parameter int IDX_T2 = 1,
  parameter int IDX_T1 = 2,
  parameter int IDX_T3 = 3,
  parameter int IDX_T4 = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCNT-1:0] cnt_up,
  input  logic [NCNT-1:0] cnt_dn,
  input  logic            tick,
  input  logic            wpctr_n,
  input  logic            rsct_n,
  input  logic            wovr_n,
  input  logic            wovc_n,
  input  logic            genrst_n,
  input  logic            wb_sg,
  input  logic            wb_us,
  output logic [1:0]      sub_sel,
  output logic [AW-1:0]   rbus,
  output logic            rbus_busy_n,
  output logic            rupt_t3,
  output logic            rupt_t4
);
  import ctr_arb_pkg::*;

  localparam int CW = (NCNT > 1) ? $clog2(NCNT) : 1;
  localparam logic [NCNT-1:0] TICK_MASK =
    NCNT'((1 << IDX_T1) | (1 << IDX_T3) | (1 << IDX_T4));

  logic            gr, do_latch, do_read, do_clear, do_ovc;
  logic            pos_ovf, neg_ovf, hit, chain_set;
  logic [NCNT-1:0] p_cell, m_cell, clr_vec;
  logic [CW-1:0]   enc_idx, sel_code;
  logic            enc_any, sel_vld;
  sub_e            sub_q, sub_nx;

  assign gr       = ~genrst_n;
  assign do_latch = ~wpctr_n;
  assign do_read  = ~rsct_n;
  assign do_clear = ~wovr_n;
  assign do_ovc   = ~wovc_n;
  assign pos_ovf  = wb_us & ~wb_sg;
  assign neg_ovf  = wb_sg & ~wb_us;
  assign hit      = do_clear & sel_vld;

  for (genvar i = 0; i < NCNT; i++) begin : g_clr
    assign clr_vec[i] = hit & (sel_code == CW'(i));
  end
  assign chain_set = hit & (sel_code == CW'(IDX_T1)) & pos_ovf;

  ctr_cells #(
    .NCNT(NCNT), .IDX_OV(IDX_OV), .IDX_T2(IDX_T2), .TICK_MASK(TICK_MASK)
  ) u_cells (
    .clk(clk), .rst(rst), .clr_all(gr),
    .up_in(cnt_up), .dn_in(cnt_dn), .tick(tick),
    .ovc_pos(do_ovc & pos_ovf), .ovc_neg(do_ovc & neg_ovf),
    .chain_set(chain_set), .clr_vec(clr_vec),
    .p_cell(p_cell), .m_cell(m_cell)
  );

  ctr_prio_enc #(.NCNT(NCNT), .CW(CW)) u_enc (
    .req(p_cell | m_cell), .idx(enc_idx), .any(enc_any)
  );

  always_comb begin
    sub_nx = SUB_NONE;
    if (enc_any) begin
      if (p_cell[enc_idx] && !m_cell[enc_idx])      sub_nx = SUB_INC;
      else if (m_cell[enc_idx] && !p_cell[enc_idx]) sub_nx = SUB_DEC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || gr) begin
      sel_code <= '0;
      sel_vld  <= 1'b0;
      sub_q    <= SUB_NONE;
    end else if (do_latch) begin
      sel_code <= enc_idx;
      sel_vld  <= enc_any;
      sub_q    <= sub_nx;
    end else if (hit) begin
      sel_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || gr) begin
      rupt_t3 <= 1'b0;
      rupt_t4 <= 1'b0;
    end else begin
      rupt_t3 <= hit & pos_ovf & (sel_code == CW'(IDX_T3));
      rupt_t4 <= hit & pos_ovf & (sel_code == CW'(IDX_T4));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbus        <= '0;
      rbus_busy_n <= 1'b1;
    end else begin
      rbus        <= do_read ? (AW'(BASE_ADDR) + AW'(sel_code)) : '0;
      rbus_busy_n <= ~do_read;
    end
  end

  assign sub_sel = sub_q;
endmodule

// File: rtl/ctr_req_arbiter_chk.sv
module ctr_req_arbiter_chk #(
  parameter int NCNT = 5,
  parameter int AW = 16,
  parameter int BASE_ADDR = 28
) (
  input logic          clk,
  input logic          rst,
  input logic          wpctr_n,
  input logic          rsct_n,
  input logic          wovr_n,
  input logic          genrst_n,
  input logic          wb_sg,
  input logic          wb_us,
  input logic          enc_any,
  input logic [1:0]    sub_sel,
  input logic [AW-1:0] rbus,
  input logic          rbus_busy_n,
  input logic          rupt_t3,
  input logic          rupt_t4
);
  // R4
  sub_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    sub_sel != 2'b11);

  // R4
  idle_latch_none_chk: assert property (@(posedge clk) disable iff (rst)
    (!wpctr_n && !enc_any) |=> sub_sel == 2'b00);

  // R1
  genrst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !genrst_n |=> (sub_sel == 2'b00 && !rupt_t3 && !rupt_t4));

  // R6
  read_drives_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !rsct_n |=> !rbus_busy_n);

  // R6
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rbus_busy_n |-> rbus == '0);

  // R6
  bus_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    !rbus_busy_n |-> (rbus >= AW'(BASE_ADDR) && rbus < AW'(BASE_ADDR + NCNT)));

  // R8
  rupt_needs_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (rupt_t3 || rupt_t4) |-> $past(!wovr_n && wb_us && !wb_sg));

  // R12
  sub_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wpctr_n && genrst_n) |=> $stable(sub_sel));
endmodule

bind ctr_req_arbiter ctr_req_arbiter_chk #(
  .NCNT(NCNT), .AW(AW), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wpctr_n(wpctr_n), .rsct_n(rsct_n),
  .wovr_n(wovr_n), .genrst_n(genrst_n), .wb_sg(wb_sg), .wb_us(wb_us),
  .enc_any(enc_any), .sub_sel(sub_sel), .rbus(rbus),
  .rbus_busy_n(rbus_busy_n), .rupt_t3(rupt_t3), .rupt_t4(rupt_t4)
);

// File: tb/sim_ctr_req_arbiter.sv
module sim_ctr_req_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] cnt_up = '0, cnt_dn = '0;
  logic tick = 1'b0;
  logic wpctr_n = 1'b1, rsct_n = 1'b1, wovr_n = 1'b1, wovc_n = 1'b1, genrst_n = 1'b1;
  logic wb_sg = 1'b0, wb_us = 1'b0;
  logic [1:0] sub_sel;
  logic [15:0] rbus;
  logic rbus_busy_n, rupt_t3, rupt_t4;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_req_arbiter u0 (
    .clk(clk), .rst(rst), .cnt_up(cnt_up), .cnt_dn(cnt_dn), .tick(tick),
    .wpctr_n(wpctr_n), .rsct_n(rsct_n), .wovr_n(wovr_n), .wovc_n(wovc_n),
    .genrst_n(genrst_n), .wb_sg(wb_sg), .wb_us(wb_us), .sub_sel(sub_sel),
    .rbus(rbus), .rbus_busy_n(rbus_busy_n), .rupt_t3(rupt_t3), .rupt_t4(rupt_t4)
  );

  // {up[4:0], dn[4:0], expected sub code[1:0], expected address[5:0]}
  localparam logic [17:0] VEC [8] = '{
    {5'b00100, 5'b00000, 2'b01, 6'o36},  // R4 plus only
    {5'b00000, 5'b00001, 2'b10, 6'o34},  // R4 minus only
    {5'b11000, 5'b00000, 2'b01, 6'o37},  // R3 lower index wins
    {5'b10100, 5'b00010, 2'b10, 6'o35},  // R3 minus request outranks
    {5'b00001, 5'b00001, 2'b00, 6'o34},  // R5 both cells
    {5'b00000, 5'b00000, 2'b00, 6'o34},  // R4 nothing pending
    {5'b10000, 5'b00000, 2'b01, 6'o40},  // R6 top address
    {5'b11111, 5'b00000, 2'b01, 6'o34}   // R3 all pending
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic req(input logic [N-1:0] u, input logic [N-1:0] d);
    cnt_up = u; cnt_dn = d; cyc();
    cnt_up = '0; cnt_dn = '0; cyc();
  endtask

  task automatic latch();
    wpctr_n = 1'b0; cyc(); wpctr_n = 1'b1;
  endtask

  task automatic clear(input logic us, input logic sg);
    wb_us = us; wb_sg = sg; wovr_n = 1'b0; cyc();
    wovr_n = 1'b1; wb_us = 1'b0; wb_sg = 1'b0;
  endtask

  task automatic ovc(input logic us, input logic sg);
    wb_us = us; wb_sg = sg; wovc_n = 1'b0; cyc();
    wovc_n = 1'b1; wb_us = 1'b0; wb_sg = 1'b0;
  endtask

  task automatic gen_reset();
    genrst_n = 1'b0; cyc(); genrst_n = 1'b1;
  endtask

  task automatic expect_sel(input string tag, input logic [1:0] sub, input logic [5:0] addr);
    latch();
    chk({tag, " sub_sel"}, 16'(sub_sel), 16'(sub));
    rsct_n = 1'b0; cyc(); rsct_n = 1'b1;
    chk({tag, " rbus"}, rbus, 16'(addr));
    chk({tag, " busy"}, 16'(rbus_busy_n), 16'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    // R1 reset state
    chk("R1 sub_sel", 16'(sub_sel), 16'd0);
    chk("R1 rbus", rbus, 16'd0);
    chk("R1 busy", 16'(rbus_busy_n), 16'd1);
    chk("R1 rupt", 16'({rupt_t3, rupt_t4}), 16'd0);

    for (int k = 0; k < 8; k++) begin
      req(VEC[k][17:13], VEC[k][12:8]);
      expect_sel($sformatf("R4 vec%0d", k), VEC[k][7:6], VEC[k][5:0]);
      cyc();
      chk("R6 idle busy", 16'(rbus_busy_n), 16'd1);
      clear(1'b0, 1'b0);
      gen_reset();
    end

    // R5 both cells cleared by one clear
    req(5'b10001, 5'b00001);
    expect_sel("R5 both", 2'b00, 6'o34);
    clear(1'b0, 1'b0);
    expect_sel("R5 after clear", 2'b01, 6'o40);
    clear(1'b0, 1'b0);
    gen_reset();

    // R2 held input does not re-request
    cnt_up = 5'b01000; cyc(); cyc();
    expect_sel("R2 first", 2'b01, 6'o37);
    clear(1'b0, 1'b0);
    expect_sel("R2 held high", 2'b00, 6'o34);
    cnt_up = '0; cyc();
    gen_reset();

    // R7 clear touches only latched counter, once per latch
    req(5'b01100, 5'b00000);
    expect_sel("R7 first", 2'b01, 6'o36);
    clear(1'b0, 1'b0);
    clear(1'b0, 1'b0);
    expect_sel("R7 remaining", 2'b01, 6'o37);
    clear(1'b0, 1'b0);
    gen_reset();

    // R8 timer overflow interrupts
    req(5'b01000, 5'b00000);
    latch();
    clear(1'b1, 1'b0);
    chk("R8 t3 pulse", 16'({rupt_t3, rupt_t4}), 16'b10);
    cyc();
    chk("R8 t3 one cycle", 16'(rupt_t3), 16'd0);
    req(5'b10000, 5'b00000);
    latch();
    clear(1'b0, 1'b1);
    chk("R8 negative ovf", 16'({rupt_t3, rupt_t4}), 16'd0);
    req(5'b10000, 5'b00000);
    latch();
    clear(1'b1, 1'b0);
    chk("R8 t4 pulse", 16'({rupt_t3, rupt_t4}), 16'b01);
    gen_reset();

    // R9 low clock word overflow chains into high word
    req(5'b00100, 5'b00000);
    latch();
    clear(1'b1, 1'b0);
    expect_sel("R9 chain", 2'b01, 6'o35);
    clear(1'b0, 1'b0);
    gen_reset();

    // R10 tick sets three timers
    tick = 1'b1; cyc(); tick = 1'b0; cyc();
    expect_sel("R10 t1", 2'b01, 6'o36);
    clear(1'b0, 1'b0);
    expect_sel("R10 t3", 2'b01, 6'o37);
    clear(1'b0, 1'b0);
    expect_sel("R10 t4", 2'b01, 6'o40);
    clear(1'b0, 1'b0);
    expect_sel("R10 drained", 2'b00, 6'o34);
    gen_reset();

    // R11 overflow check into overflow counter
    ovc(1'b1, 1'b0);
    expect_sel("R11 positive", 2'b01, 6'o34);
    clear(1'b0, 1'b0);
    ovc(1'b0, 1'b1);
    expect_sel("R11 negative", 2'b10, 6'o34);
    clear(1'b0, 1'b0);
    ovc(1'b1, 1'b1);
    expect_sel("R11 no overflow", 2'b00, 6'o34);
    gen_reset();

    // R12 code held until next latch
    req(5'b01000, 5'b00000);
    latch();
    req(5'b00001, 5'b00000);
    cyc(); cyc();
    chk("R12 hold", 16'(sub_sel), 16'b01);

    // R1 general reset empties cells
    req(5'b11111, 5'b11111);
    gen_reset();
    chk("R1 genrst sub", 16'(sub_sel), 16'd0);
    expect_sel("R1 genrst cells", 2'b00, 6'o34);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule